// File: doc/BRIEF.md
# Byte-Parity Double-Data-Rate SRAM Data Path

This block sits between a requester that works in 32-bit words and a quad-data-rate style static RAM port. The memory port has 16 data pins that carry one half-word on each clock edge, plus one parity pin per byte lane. Each edge is modelled here as a separate beat: a rising beat and a falling beat, both presented in the same clock cycle. Read data and write data use separate buses, as quad-data-rate parts require. One address bus is shared, and only one memory cycle (read or write) is issued per clock.

On a write, the block splits the word into its two beats and attaches an even parity bit to every byte. It drives one write strobe per byte from the requester's byte enables, so the memory leaves unselected lanes alone (data and parity alike). On a read, it waits a fixed memory latency, joins the two returned beats into a word and checks each byte against its stored parity bit. The result is a per-byte error vector that comes out with the data.

A request names its length in words. A length of one or two is carried out as one or two back-to-back memory cycles at consecutive addresses. Any other length is refused with a one-cycle error pulse, and no memory cycle is issued for it.

Top module: `qdr_parity_datapath`

## Requirements
- R1: After reset, `req_ready` is 1, and `req_err`, `rd_valid`, `mem_wr_en` and `mem_rd_en` are all 0.
- R2: A write of length 1 accepted at a clock edge drives `mem_wr_en`=1 and `mem_addr`=`req_addr` in the following cycle. In that cycle, bits [15:0] of `mem_d_rise` carry word bits [15:0], and bits [15:0] of `mem_d_fall` carry word bits [31:16].
- R3: On each beat, pin bit 16 is the even parity of data bits [7:0] (the XOR of those bits), and pin bit 17 is the even parity of data bits [15:8].
- R4: Byte enable bit i selects byte i of the word. `mem_bwe_rise` equals bits [1:0] of the enables and `mem_bwe_fall` equals bits [3:2]. After a masked write, bytes whose enable was 0 read back with their former data and no parity error.
- R5: `rd_valid` rises exactly RD_LAT+1 cycles after a cycle with `mem_rd_en`=1. `rd_data` is {`mem_q_fall`[15:0], `mem_q_rise`[15:0]}, taken from the beats that were present RD_LAT cycles after the read cycle.
- R6: `rd_perr` bit i is 1, together with `rd_valid`, exactly when byte i and its returned parity bit hold an odd number of ones. Bytes 0 and 1 use `mem_q_rise` (parity bits 16 and 17), and bytes 2 and 3 use `mem_q_fall`.
- R7: A request with `req_len`=2 issues two memory cycles in consecutive clocks of the same direction. The addresses are A and A+1 (the second wraps modulo 2^ADDR_W). The second write beat uses `req_wdata1`/`req_be1`. `req_ready` is 0 during the first of the two cycles only.
- R8: A request with `req_len` of 0 or 3 produces `req_err`=1 for exactly the next cycle, with no memory cycle, and `req_ready` stays 1.
- R9: `mem_wr_en` and `mem_rd_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Burst length in words (1 or 2 legal) |
| req_addr | input | ADDR_W | Word address of the first word |
| req_wdata0 | input | 32 | Write data, first word |
| req_wdata1 | input | 32 | Write data, second word |
| req_be0 | input | 4 | Byte enables, first word |
| req_be1 | input | 4 | Byte enables, second word |
| req_ready | output | 1 | Request accepted when high |
| req_err | output | 1 | Illegal length refused (one cycle) |
| rd_valid | output | 1 | Read word present |
| rd_data | output | 32 | Reassembled read word |
| rd_perr | output | 4 | Per-byte parity error |
| mem_wr_en | output | 1 | Memory write cycle |
| mem_rd_en | output | 1 | Memory read cycle |
| mem_addr | output | ADDR_W | Memory word address |
| mem_d_rise | output | 18 | Rising-edge write beat (parity in 17:16) |
| mem_d_fall | output | 18 | Falling-edge write beat (parity in 17:16) |
| mem_bwe_rise | output | 2 | Byte write strobes, rising beat |
| mem_bwe_fall | output | 2 | Byte write strobes, falling beat |
| mem_q_rise | input | 18 | Rising-edge read beat |
| mem_q_fall | input | 18 | Falling-edge read beat |

## Verification
The bound checker watches several properties on every cycle. It checks that reads and writes never overlap, that a refusal never coincides with a memory cycle, and that a burst never runs past two cycles, steps its address by one and keeps its direction. It also checks that parity on both write beats is correct whenever a write is issued, and that no read word appears without an outstanding read. Other behaviours can only be shown by the bench's scenarios against a memory model that honours the strobes. These are whether masked lanes really keep their old data and parity, the exact read latency and beat ordering, and the mapping of corrupted stored bits to the right bit of `rd_perr`.

// File: rtl/qpd_pkg.sv
// Shared widths and parity helpers for the byte-parity DDR SRAM data path.
// Assumes two beats per clock and a word that splits evenly into them.
package qpd_pkg;
    localparam int WORD_BYTES = 4;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = WORD_BYTES * BYTE_W;
    localparam int BEATS      = 2;
    localparam int LANES      = WORD_BYTES / BEATS;
    localparam int HALF_W     = LANES * BYTE_W;
    localparam int PIN_W      = HALF_W + LANES;
    localparam int LEN_W      = 2;
    localparam int MAX_BURST  = 2;

    typedef logic [PIN_W-1:0] pin_beat_t;

    // Even parity of every byte lane of one half-word.
    function automatic logic [LANES-1:0] lane_parity(input logic [HALF_W-1:0] h);
        logic [LANES-1:0] p;
        for (int i = 0; i < LANES; i++) p[i] = ^h[i*BYTE_W +: BYTE_W];
        return p;
    endfunction

    // Half-word plus its lane parity bits, as placed on the pins.
    function automatic pin_beat_t pack_beat(input logic [HALF_W-1:0] h);
        return {lane_parity(h), h};
    endfunction
endpackage

// File: rtl/qpd_burst_ctrl.sv
// Request sequencer: accepts a request when idle, refuses illegal lengths,
// and issues one or two memory cycles at consecutive addresses.
// Assumes the requester holds nothing after acceptance; the second word's
// data is captured elsewhere on the load0 strobe.
module qpd_burst_ctrl
    import qpd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              req_err,
    output logic              load0,
    output logic              load1,
    output logic              iss_valid,
    output logic              iss_write,
    output logic [ADDR_W-1:0] iss_addr
);
    logic              pend_q;
    logic              pend_write_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              len_ok;

    // Legal lengths are 1 up to the supported burst.
    assign len_ok    = (req_len != '0) && (int'(req_len) <= MAX_BURST);
    assign req_ready = !pend_q;
    assign load0     = req_valid && req_ready && len_ok;
    assign load1     = pend_q;

    // Issue registers and pending second beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_write_q <= 1'b0;
            pend_addr_q  <= '0;
            req_err      <= 1'b0;
            iss_valid    <= 1'b0;
            iss_write    <= 1'b0;
            iss_addr     <= '0;
        end else begin
            req_err   <= req_valid && req_ready && !len_ok;
            iss_valid <= load0 || load1;
            if (load1) begin
                iss_write <= pend_write_q;
                iss_addr  <= pend_addr_q;
                pend_q    <= 1'b0;
            end else if (load0) begin
                iss_write    <= req_write;
                iss_addr     <= req_addr;
                pend_q       <= (int'(req_len) == MAX_BURST);
                pend_write_q <= req_write;
                pend_addr_q  <= req_addr + ADDR_W'(1);
            end
        end
    end
endmodule

// File: rtl/qpd_wr_path.sv
// Write serialiser: splits a word into rising and falling beats, adds even
// byte parity and maps byte enables to per-beat strobes.
// Assumes load0 and load1 are never high together.
module qpd_wr_path
    import qpd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load0,
    input  logic                  load1,
    input  logic [WORD_W-1:0]     wdata0,
    input  logic [WORD_W-1:0]     wdata1,
    input  logic [WORD_BYTES-1:0] be0,
    input  logic [WORD_BYTES-1:0] be1,
    output logic [PIN_W-1:0]      d_rise,
    output logic [PIN_W-1:0]      d_fall,
    output logic [LANES-1:0]      bwe_rise,
    output logic [LANES-1:0]      bwe_fall
);
    logic [WORD_W-1:0]     hold_data_q;
    logic [WORD_BYTES-1:0] hold_be_q;
    logic [PIN_W-1:0]      beat_q [BEATS];
    logic [LANES-1:0]      bwe_q  [BEATS];

    // Keep the second word of a burst until its beat is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data_q <= '0;
            hold_be_q   <= '0;
        end else if (load0) begin
            hold_data_q <= wdata1;
            hold_be_q   <= be1;
        end
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        // Register one beat's pins and strobes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                beat_q[b] <= '0;
                bwe_q[b]  <= '0;
            end else if (load0) begin
                beat_q[b] <= pack_beat(wdata0[b*HALF_W +: HALF_W]);
                bwe_q[b]  <= be0[b*LANES +: LANES];
            end else if (load1) begin
                beat_q[b] <= pack_beat(hold_data_q[b*HALF_W +: HALF_W]);
                bwe_q[b]  <= hold_be_q[b*LANES +: LANES];
            end
        end
    end

    assign d_rise   = beat_q[0];
    assign d_fall   = beat_q[1];
    assign bwe_rise = bwe_q[0];
    assign bwe_fall = bwe_q[1];
endmodule

// File: rtl/qpd_rd_path.sv
// Read deserialiser: tracks the fixed memory latency, joins the two beats
// into a word and flags every byte whose parity is odd.
// Assumes memory returns data exactly RD_LAT cycles after a read cycle.
module qpd_rd_path
    import qpd_pkg::*;
#(
    parameter int RD_LAT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_issue,
    input  logic [PIN_W-1:0]      q_rise,
    input  logic [PIN_W-1:0]      q_fall,
    output logic                  rd_valid,
    output logic [WORD_W-1:0]     rd_data,
    output logic [WORD_BYTES-1:0] rd_perr
);
    logic [RD_LAT-1:0]     lat_q;
    logic [PIN_W-1:0]      q_in [BEATS];
    logic [WORD_W-1:0]     word_c;
    logic [WORD_BYTES-1:0] perr_c;

    assign q_in[0] = q_rise;
    assign q_in[1] = q_fall;

    if (RD_LAT == 1) begin : g_lat1
        // Single-stage latency tracker.
        always_ff @(posedge clk) begin
            if (!rst_n) lat_q <= '0;
            else        lat_q <= rd_issue;
        end
    end else begin : g_latn
        // Multi-stage latency tracker.
        always_ff @(posedge clk) begin
            if (!rst_n) lat_q <= '0;
            else        lat_q <= {lat_q[RD_LAT-2:0], rd_issue};
        end
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_join
        assign word_c[b*HALF_W +: HALF_W] = q_in[b][HALF_W-1:0];
        assign perr_c[b*LANES +: LANES]   = lane_parity(q_in[b][HALF_W-1:0])
                                          ^ q_in[b][PIN_W-1:HALF_W];
    end

    // Capture the returned word and its parity result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_perr  <= '0;
        end else begin
            rd_valid <= lat_q[RD_LAT-1];
            if (lat_q[RD_LAT-1]) begin
                rd_data <= word_c;
                rd_perr <= perr_c;
            end
        end
    end
endmodule

// File: rtl/qdr_parity_datapath.sv
// Top of the byte-parity DDR SRAM data path: sequencer, write serialiser
// and read deserialiser. Assumes a memory with per-byte write strobes and a
// fixed read latency of RD_LAT cycles.
module qdr_parity_datapath
    import qpd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RD_LAT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_W-1:0]     req_wdata0,
    input  logic [WORD_W-1:0]     req_wdata1,
    input  logic [WORD_BYTES-1:0] req_be0,
    input  logic [WORD_BYTES-1:0] req_be1,
    output logic                  req_ready,
    output logic                  req_err,
    output logic                  rd_valid,
    output logic [WORD_W-1:0]     rd_data,
    output logic [WORD_BYTES-1:0] rd_perr,
    output logic                  mem_wr_en,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [PIN_W-1:0]      mem_d_rise,
    output logic [PIN_W-1:0]      mem_d_fall,
    output logic [LANES-1:0]      mem_bwe_rise,
    output logic [LANES-1:0]      mem_bwe_fall,
    input  logic [PIN_W-1:0]      mem_q_rise,
    input  logic [PIN_W-1:0]      mem_q_fall
);
    logic load0, load1, iss_valid, iss_write;

    qpd_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_len   (req_len),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .req_err   (req_err),
        .load0     (load0),
        .load1     (load1),
        .iss_valid (iss_valid),
        .iss_write (iss_write),
        .iss_addr  (mem_addr)
    );

    assign mem_wr_en = iss_valid && iss_write;
    assign mem_rd_en = iss_valid && !iss_write;

    qpd_wr_path u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load0    (load0),
        .load1    (load1),
        .wdata0   (req_wdata0),
        .wdata1   (req_wdata1),
        .be0      (req_be0),
        .be1      (req_be1),
        .d_rise   (mem_d_rise),
        .d_fall   (mem_d_fall),
        .bwe_rise (mem_bwe_rise),
        .bwe_fall (mem_bwe_fall)
    );

    qpd_rd_path #(.RD_LAT(RD_LAT)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (mem_rd_en),
        .q_rise   (mem_q_rise),
        .q_fall   (mem_q_fall),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_perr  (rd_perr)
    );
endmodule

// File: rtl/qpd_checker.sv
// Cycle-by-cycle protocol checks for qdr_parity_datapath, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module qpd_checker
    import qpd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LEN_W-1:0]  req_len,
    input logic              req_ready,
    input logic              req_err,
    input logic              mem_wr_en,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PIN_W-1:0]  mem_d_rise,
    input logic [PIN_W-1:0]  mem_d_fall,
    input logic              rd_valid
);
    logic [7:0] open_rd_q;

    // Count reads issued but not yet returned.
    always_ff @(posedge clk) begin
        if (!rst_n) open_rd_q <= '0;
        else        open_rd_q <= open_rd_q + {7'd0, mem_rd_en} - {7'd0, rd_valid};
    end

    // R9
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && mem_rd_en));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!mem_wr_en && !mem_rd_en && req_ready));

    // R7
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    // R7
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (mem_addr == $past(mem_addr) + ADDR_W'(1))
                       && (mem_wr_en == $past(mem_wr_en))
                       && (mem_rd_en == $past(mem_rd_en)));

    // R7
    burst_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid && (req_len == 2'd2)));

    // R3
    wr_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_d_rise[16] == ^mem_d_rise[7:0])
                   && (mem_d_rise[17] == ^mem_d_rise[15:8])
                   && (mem_d_fall[16] == ^mem_d_fall[7:0])
                   && (mem_d_fall[17] == ^mem_d_fall[15:8]));

    // R5
    rd_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (open_rd_q != 8'd0));
endmodule

bind qdr_parity_datapath qpd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .req_ready  (req_ready),
    .req_err    (req_err),
    .mem_wr_en  (mem_wr_en),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .mem_d_rise (mem_d_rise),
    .mem_d_fall (mem_d_fall),
    .rd_valid   (rd_valid)
);

// File: tb/qdr_parity_datapath_tb.sv
module qdr_parity_datapath_tb;
    localparam int AW  = 4;
    localparam int LAT = 2;
    localparam int N   = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_len = 2'd1;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata0 = '0, req_wdata1 = '0;
    logic [3:0]  req_be0 = '0, req_be1 = '0;
    logic        req_ready, req_err, rd_valid, mem_wr_en, mem_rd_en;
    logic [31:0] rd_data;
    logic [3:0]  rd_perr;
    logic [AW-1:0] mem_addr;
    logic [17:0] mem_d_rise, mem_d_fall, mem_q_rise, mem_q_fall;
    logic [1:0]  mem_bwe_rise, mem_bwe_fall;

    int total = 0, bad = 0;
    logic [17:0] inj_r = '0, inj_f = '0;
    logic [31:0] shadow [N];
    logic [17:0] store_r [N], store_f [N];
    logic [17:0] pipe_r [LAT], pipe_f [LAT];

    always #10 clk = ~clk;

    qdr_parity_datapath #(.ADDR_W(AW), .RD_LAT(LAT)) u_dut (.*);

    // Memory model: byte-strobed writes, fixed-latency reads.
    always @(posedge clk) begin
        if (mem_wr_en) begin
            for (int l = 0; l < 2; l++) begin
                if (mem_bwe_rise[l]) begin
                    store_r[mem_addr][l*8 +: 8] <= mem_d_rise[l*8 +: 8];
                    store_r[mem_addr][16+l]     <= mem_d_rise[16+l];
                end
                if (mem_bwe_fall[l]) begin
                    store_f[mem_addr][l*8 +: 8] <= mem_d_fall[l*8 +: 8];
                    store_f[mem_addr][16+l]     <= mem_d_fall[16+l];
                end
            end
        end
        pipe_r[0] <= store_r[mem_addr];
        pipe_f[0] <= store_f[mem_addr];
        for (int s = 1; s < LAT; s++) begin
            pipe_r[s] <= pipe_r[s-1];
            pipe_f[s] <= pipe_f[s-1];
        end
    end
    assign mem_q_rise = pipe_r[LAT-1] ^ inj_r;
    assign mem_q_fall = pipe_f[LAT-1] ^ inj_f;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] pins(input logic [15:0] h);
        return {^h[15:8], ^h[7:0], h};
    endfunction

    function automatic logic [3:0] flip_err(input logic [17:0] r, input logic [17:0] f);
        return {^{f[15:8], f[17]}, ^{f[7:0], f[16]}, ^{r[15:8], r[17]}, ^{r[7:0], r[16]}};
    endfunction

    task automatic merge(input logic [AW-1:0] a, input logic [31:0] w, input logic [3:0] be);
        for (int i = 0; i < 4; i++) if (be[i]) shadow[a][i*8 +: 8] = w[i*8 +: 8];
    endtask

    task automatic check_wbeat(input logic [AW-1:0] a, input logic [31:0] w, input logic [3:0] be);
        chk(mem_wr_en && !mem_rd_en, "R2 write cycle / R9", {mem_wr_en, mem_rd_en}, 2'b10);
        chk(mem_addr == a, "R2 address", mem_addr, a);
        chk(mem_d_rise == pins(w[15:0]), "R2 R3 rising beat", mem_d_rise, pins(w[15:0]));
        chk(mem_d_fall == pins(w[31:16]), "R2 R3 falling beat", mem_d_fall, pins(w[31:16]));
        chk({mem_bwe_fall, mem_bwe_rise} == be, "R4 strobes", {mem_bwe_fall, mem_bwe_rise}, be);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [1:0] len,
                            input logic [31:0] w0, input logic [31:0] w1,
                            input logic [3:0] b0, input logic [3:0] b1);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_len = len; req_addr = a;
        req_wdata0 = w0; req_wdata1 = w1; req_be0 = b0; req_be1 = b1;
        @(negedge clk);
        req_valid = 0;
        check_wbeat(a, w0, b0);
        merge(a, w0, b0);
        if (len == 2'd2) begin
            chk(!req_ready, "R7 ready low in first beat", req_ready, 1'b0);
            @(negedge clk);
            check_wbeat(a + AW'(1), w1, b1);
            chk(req_ready, "R7 ready back", req_ready, 1'b1);
            merge(a + AW'(1), w1, b1);
        end
        @(negedge clk);
        chk(!mem_wr_en, "R7 no extra beat", mem_wr_en, 1'b0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] len);
        logic [31:0] flipw;
        logic [3:0]  eperr;
        flipw = {inj_f[15:0], inj_r[15:0]};
        eperr = flip_err(inj_r, inj_f);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_len = len; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk(mem_rd_en && !mem_wr_en, "R9 read cycle", {mem_wr_en, mem_rd_en}, 2'b01);
        chk(mem_addr == a, "R5 read address", mem_addr, a);
        if (len == 2'd2) begin
            @(negedge clk);
            chk(mem_rd_en && mem_addr == a + AW'(1), "R7 second read", {mem_rd_en, mem_addr}, {1'b1, a + AW'(1)});
            repeat (LAT - 1) @(negedge clk);
        end else begin
            repeat (LAT) @(negedge clk);
            chk(!rd_valid, "R5 not early", rd_valid, 1'b0);
        end
        @(negedge clk);
        chk(rd_valid, "R5 valid at latency", rd_valid, 1'b1);
        chk(rd_data == (shadow[a] ^ flipw), "R4 R5 read data", rd_data, shadow[a] ^ flipw);
        chk(rd_perr == eperr, "R6 parity result", rd_perr, eperr);
        if (len == 2'd2) begin
            @(negedge clk);
            chk(rd_valid && rd_data == (shadow[a + AW'(1)] ^ flipw), "R7 second word",
                rd_data, shadow[a + AW'(1)] ^ flipw);
            chk(rd_perr == eperr, "R6 second parity", rd_perr, eperr);
        end
        @(negedge clk);
        chk(!rd_valid, "R5 single pulse", rd_valid, 1'b0);
    endtask

    task automatic do_bad(input logic wr, input logic [1:0] len);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_len = len; req_addr = 3;
        req_wdata0 = 32'hFFFF_FFFF; req_be0 = 4'hF;
        @(negedge clk);
        req_valid = 0;
        chk(req_err && !mem_wr_en && !mem_rd_en && req_ready, "R8 refused",
            {req_err, mem_wr_en, mem_rd_en, req_ready}, 4'b1001);
        @(negedge clk);
        chk(!req_err && !mem_wr_en && !mem_rd_en, "R8 one-cycle pulse",
            {req_err, mem_wr_en, mem_rd_en}, 3'b000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !req_err && !rd_valid && !mem_wr_en && !mem_rd_en, "R1 reset",
            {req_ready, req_err, rd_valid, mem_wr_en, mem_rd_en}, 5'b10000);
        rst_n = 1;
        // Fill every address with a full word, then read it back.
        for (int a = 0; a < N; a++) do_write(AW'(a), 2'd1, 32'h9E37_79B9 * (a + 1), '0, 4'hF, 4'h0);
        for (int a = 0; a < N; a++) do_read(AW'(a), 2'd1);
        // R4 sweep of all byte enable patterns.
        for (int be = 0; be < 16; be++) begin
            do_write(AW'(be), 2'd1, 32'hC3A5_5A3C ^ (be * 32'h0101_0101), '0, 4'(be), 4'h0);
            do_read(AW'(be), 2'd1);
        end
        // R7 bursts, including wrap at the top address.
        for (int k = 0; k < N; k += 3) begin
            do_write(AW'(k), 2'd2, 32'h1234_5678 + k, 32'h8765_4321 - k, 4'(k), 4'(~k));
            do_read(AW'(k), 2'd2);
        end
        do_write(AW'(N - 1), 2'd2, 32'hDEAD_BEEF, 32'h0BAD_F00D, 4'hF, 4'hF);
        do_read(AW'(N - 1), 2'd2);
        // R8 illegal lengths, then show memory untouched.
        do_bad(1'b1, 2'd0);
        do_bad(1'b1, 2'd3);
        do_bad(1'b0, 2'd0);
        do_bad(1'b0, 2'd3);
        do_read(AW'(3), 2'd1);
        // R6 single-bit corruption on every returned pin.
        for (int b = 0; b < 36; b++) begin
            inj_r = (b < 18) ? (18'd1 << b) : '0;
            inj_f = (b >= 18) ? (18'd1 << (b - 18)) : '0;
            do_read(AW'(5), 2'd1);
        end
        inj_r = 18'h30001;
        inj_f = 18'h00300;
        do_read(AW'(6), 2'd1);
        inj_r = '0;
        inj_f = '0;
        do_read(AW'(6), 2'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule